// File: doc/BRIEF.md
# Timer Compare Waveform Unit

This block is a 16-bit free-running timer with two compare channels, A and B. Each channel owns one waveform latch. On every counter step the latch is toggled, cleared or set, or left alone. What happens depends on a 2-bit compare action field in a byte-wide control register, on the waveform mode, and on whether the count equals the channel's compare value or the TOP limit. The counter runs from 0 up to `top_val`, then returns to 0. It advances only while `cnt_en` is high.

The waveform mode is four bits wide. Its upper two bits come from the `wgm_hi` input and its lower two bits from control bits 1:0. When the mode has bit 2 set and a nonzero low pair, the block works as a fast PWM generator. In that case compare values are double-buffered and are picked up only at the TOP wrap. Every other mode value gives plain compare behaviour, in which the compare inputs are used directly.

Each channel also reports two things for the pad logic. The override flag says the compare output replaces normal port function. The driver enable also requires the pin's direction bit.

Top module: `tmr_cmp_wave`

## Requirements
- R1: The control register resets to 0x00. A write stores bits 7:6 (channel A action), bits 5:4 (channel B action) and bits 1:0 (low mode bits). Bits 3:2 always read back as 0, so writing 0xFF reads back 0xF3.
- R2: The counter steps 0,1,…,`top_val`,0,… by one per cycle while `cnt_en` is 1. A period therefore lasts `top_val`+1 cycles.
- R3: In plain mode (mode value 0000), action 01 toggles the latch whenever the count equals the channel compare value. The latch output therefore repeats every 2·(`top_val`+1) cycles.
- R4: In plain mode, action 10 clears the latch on a compare match and action 11 sets it on a match.
- R5: In fast PWM (for example mode 0111), action 10 sets the latch at TOP and clears it on a match. With compare below TOP, the latch is high for compare+1 of every `top_val`+1 cycles.
- R6: In fast PWM, action 11 clears the latch at TOP and sets it on a match. It is then high for `top_val`−compare of every period.
- R7: In fast PWM, when a compare value equals TOP and the channel action is 10 or 11, the match is suppressed and only the TOP action applies. Action 10 then stays high all the time and action 11 stays low all the time.
- R8: In fast PWM, action 01 toggles channel A on a match only when mode bit 3 (`wgm_hi[1]`) is 1. Channel B never changes under action 01, and channel A does not change under action 01 when mode bit 3 is 0.
- R9: `ovr_x` is 1 exactly when channel x's action field is nonzero. `oe_x` is `ovr_x` AND `dir_x`.
- R10: Both latches reset to 0, and they follow their actions whatever the values of `dir_x` and `oe_x`.
- R11: In fast PWM, a change to a compare input takes effect only after the next TOP wrap.
- R12: While `cnt_en` is 0, the counter and both latches hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Counter step enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd | output | 8 | Control register contents |
| wgm_hi | input | 2 | Mode bits 3:2 |
| top_val | input | 16 | Counter TOP limit |
| cmp_a | input | 16 | Channel A compare value |
| cmp_b | input | 16 | Channel B compare value |
| dir_a | input | 1 | Direction bit of pin A |
| dir_b | input | 1 | Direction bit of pin B |
| wav_a | output | 1 | Channel A waveform latch |
| wav_b | output | 1 | Channel B waveform latch |
| ovr_a | output | 1 | Channel A overrides port function |
| ovr_b | output | 1 | Channel B overrides port function |
| oe_a | output | 1 | Channel A pin driver enable |
| oe_b | output | 1 | Channel B pin driver enable |

## Verification
The compare-equals-TOP case is tested in both fast PWM polarities. A design that lets the match win would drive action 10 permanently low, where the correct result is permanently high. The buffering test changes the compare value in the middle of a period. An unbuffered design would shorten that same period's pulse from 8 high cycles to 4.

The channel-A-only toggle is tested with mode bit 3 at both values. Either a toggling B or an A that toggles with bit 3 clear shows up as a nonzero transition count. Duty and toggle counts are taken over whole periods, so an off-by-one wrap at TOP alters every measured count.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TGL  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_SET  = 2'd3
  } wave_act_e;

  localparam int CTL_W = 8;
  localparam logic [CTL_W-1:0] CTL_WMASK = 8'hF3;
endpackage

// File: rtl/tcw_rst_sync.sv
module tcw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rs_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb sh_nxt = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rs_n = sh_q[STAGES-1];
endmodule

// File: rtl/tcw_counter.sv
module tcw_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rs_n,
  input  logic          cnt_en,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt,
  output logic          top_ev
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          at_top;

  always_comb begin
    at_top  = (cnt_q == top_val);
    cnt_nxt = cnt_q;
    if (cnt_en) cnt_nxt = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) cnt_q <= '0;
    else       cnt_q <= cnt_nxt;
  end

  assign cnt    = cnt_q;
  assign top_ev = cnt_en & at_top;
endmodule

// File: rtl/tcw_chan.sv
module tcw_chan
  import tcw_pkg::*;
#(
  parameter int CW      = 16,
  parameter bit PWM_TGL = 1'b0
) (
  input  logic          clk,
  input  logic          rs_n,
  input  logic          cnt_en,
  input  logic          pwm,
  input  logic          wgm13,
  input  logic [1:0]    act_fld,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] cnt,
  input  logic          top_ev,
  output logic          wav
);
  logic [CW-1:0] buf_q, buf_nxt;
  logic [CW-1:0] cmp_eff;
  logic          match;
  logic          wav_q, wav_nxt;
  wave_act_e     act;

  // Compare buffer: transparent outside PWM, reloaded at TOP inside it
  always_comb begin
    buf_nxt = buf_q;
    if (!pwm || top_ev) buf_nxt = cmp;
    cmp_eff = pwm ? buf_q : cmp;
    match   = cnt_en & (cnt == cmp_eff);
  end

  always_comb begin
    act = ACT_NONE;
    if (!pwm) begin
      if (match) act = wave_act_e'(act_fld);
    end else if (act_fld[1] && top_ev) begin
      // TOP action wins; a coincident match is suppressed
      act = act_fld[0] ? ACT_CLR : ACT_SET;
    end else if (match) begin
      unique case (act_fld)
        2'b01:   act = (PWM_TGL && wgm13) ? ACT_TGL : ACT_NONE;
        2'b10:   act = ACT_CLR;
        2'b11:   act = ACT_SET;
        default: act = ACT_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (act)
      ACT_TGL: wav_nxt = ~wav_q;
      ACT_CLR: wav_nxt = 1'b0;
      ACT_SET: wav_nxt = 1'b1;
      default: wav_nxt = wav_q;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      buf_q <= '0;
      wav_q <= 1'b0;
    end else begin
      buf_q <= buf_nxt;
      wav_q <= wav_nxt;
    end
  end

  assign wav = wav_q;
endmodule

// File: rtl/tmr_cmp_wave.sv
module tmr_cmp_wave
  import tcw_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rd,
  input  logic [1:0]    wgm_hi,
  input  logic [CW-1:0] top_val,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          dir_a,
  input  logic          dir_b,
  output logic          wav_a,
  output logic          wav_b,
  output logic          ovr_a,
  output logic          ovr_b,
  output logic          oe_a,
  output logic          oe_b
);
  localparam int NCH = 2;

  logic          rs_n;
  logic [7:0]    ctl_q, ctl_nxt;
  logic [3:0]    wgm;
  logic          pwm;
  logic [CW-1:0] cnt;
  logic          top_ev;

  logic [NCH-1:0][CW-1:0] cmp_arr;
  logic [NCH-1:0][1:0]    fld_arr;
  logic [NCH-1:0]         dir_arr, wav_arr, ovr_arr;

  tcw_rst_sync #(.STAGES(2)) u_rs (.clk(clk), .rst_n(rst_n), .rs_n(rs_n));

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_we) ctl_nxt = ctl_wdata & CTL_WMASK;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) ctl_q <= '0;
    else       ctl_q <= ctl_nxt;
  end

  assign ctl_rd = ctl_q;
  assign wgm    = {wgm_hi, ctl_q[1:0]};
  assign pwm    = wgm[2] & (wgm[1:0] != 2'b00);

  tcw_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rs_n(rs_n), .cnt_en(cnt_en), .top_val(top_val),
    .cnt(cnt), .top_ev(top_ev)
  );

  assign cmp_arr = {cmp_b, cmp_a};
  assign fld_arr = {ctl_q[5:4], ctl_q[7:6]};
  assign dir_arr = {dir_b, dir_a};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tcw_chan #(.CW(CW), .PWM_TGL(i == 0)) u_ch (
      .clk(clk), .rs_n(rs_n), .cnt_en(cnt_en), .pwm(pwm), .wgm13(wgm[3]),
      .act_fld(fld_arr[i]), .cmp(cmp_arr[i]), .cnt(cnt), .top_ev(top_ev),
      .wav(wav_arr[i])
    );
    assign ovr_arr[i] = (fld_arr[i] != 2'b00);
  end

  assign wav_a = wav_arr[0];
  assign wav_b = wav_arr[1];
  assign ovr_a = ovr_arr[0];
  assign ovr_b = ovr_arr[1];
  assign oe_a  = ovr_arr[0] & dir_arr[0];
  assign oe_b  = ovr_arr[1] & dir_arr[1];
endmodule

// File: rtl/tcw_chk.sv
module tcw_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rs_n,
  input logic          cnt_en,
  input logic          pwm,
  input logic          top_ev,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] top_val,
  input logic [CW-1:0] cmp_a,
  input logic [7:0]    ctl_rd,
  input logic          dir_a,
  input logic          wav_a,
  input logic          wav_b,
  input logic          ovr_a,
  input logic          oe_a
);
  p_ro_zero_r1: assert property (@(posedge clk) disable iff (!rs_n)
    ctl_rd[3:2] == 2'b00);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rs_n)
    (cnt_en && cnt == top_val) |=> (cnt == '0));

  p_clr_match_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (!pwm && ctl_rd[7:6] == 2'b10 && cnt_en && cnt == cmp_a) |=> !wav_a);

  p_top_set_r5: assert property (@(posedge clk) disable iff (!rs_n)
    (pwm && ctl_rd[7:6] == 2'b10 && top_ev) |=> wav_a);

  p_ovr_r9: assert property (@(posedge clk) disable iff (!rs_n)
    ovr_a == (ctl_rd[7:6] != 2'b00));

  p_oe_r9: assert property (@(posedge clk) disable iff (!rs_n)
    oe_a |-> (ovr_a && dir_a));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rs_n)
    !cnt_en |=> ($stable(wav_a) && $stable(wav_b)));
endmodule

bind tmr_cmp_wave tcw_chk #(.CW(CW)) u_chk (
  .clk(clk), .rs_n(rs_n), .cnt_en(cnt_en), .pwm(pwm), .top_ev(top_ev),
  .cnt(cnt), .top_val(top_val), .cmp_a(cmp_a), .ctl_rd(ctl_rd),
  .dir_a(dir_a), .wav_a(wav_a), .wav_b(wav_b), .ovr_a(ovr_a), .oe_a(oe_a)
);

// File: tb/tb_tmr_cmp_wave.sv
module tb_tmr_cmp_wave;
  logic        clk = 1'b0;
  logic        rst_n, cnt_en, ctl_we, dir_a, dir_b;
  logic [7:0]  ctl_wdata, ctl_rd;
  logic [1:0]  wgm_hi;
  logic [15:0] top_val, cmp_a, cmp_b;
  logic        wav_a, wav_b, ovr_a, ovr_b, oe_a, oe_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_cmp_wave dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .wgm_hi(wgm_hi),
    .top_val(top_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .dir_a(dir_a),
    .dir_b(dir_b), .wav_a(wav_a), .wav_b(wav_b), .ovr_a(ovr_a),
    .ovr_b(ovr_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    wgm_hi = 2'b00; top_val = 16'd9; cmp_a = '0; cmp_b = '0;
    dir_a = 1'b0; dir_b = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wdata = d; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic count_high(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wav_a) ha++;
      if (wav_b) hb++;
    end
  endtask

  task automatic count_tgl(input int n, output int ta, output int tb);
    logic pa, pb;
    ta = 0; tb = 0;
    @(negedge clk);
    pa = wav_a; pb = wav_b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wav_a != pa) ta++;
      if (wav_b != pb) tb++;
      pa = wav_a; pb = wav_b;
    end
  endtask

  task automatic t_reset_ctl();
    do_reset();
    chk("R1 ctl reset", ctl_rd, 0);
    chk("R10 wav_a reset", wav_a, 0);
    chk("R10 wav_b reset", wav_b, 0);
    chk("R9 ovr_a reset", ovr_a, 0);
    chk("R9 oe_b reset", oe_b, 0);
    wr_ctl(8'hFF);
    chk("R1 ro bits", ctl_rd, 8'hF3);
    wr_ctl(8'h52);
    chk("R1 write", ctl_rd, 8'h52);
  endtask

  task automatic t_toggle();
    int ta, tb;
    do_reset();
    top_val = 16'd4; cmp_a = 16'd2; cmp_b = 16'd0;
    wr_ctl(8'b01_01_0000);
    cnt_en = 1'b1;
    count_tgl(20, ta, tb);
    chk("R3 R2 toggles A per 4 periods", ta, 4);
    chk("R3 toggles B per 4 periods", tb, 4);
    chk("R10 oe_a off while dir_a=0", oe_a, 0);
    chk("R9 ovr_a with action 01", ovr_a, 1);
  endtask

  task automatic t_set_clr();
    int ha, hb;
    do_reset();
    top_val = 16'd5; cmp_a = 16'd3; cmp_b = 16'd1;
    wr_ctl(8'b11_11_0000);
    cnt_en = 1'b1;
    count_high(12, ha, hb);
    chk("R4 set on match A", wav_a, 1);
    chk("R4 set on match B", wav_b, 1);
    wr_ctl(8'b10_11_0000);
    count_high(12, ha, hb);
    chk("R4 clear on match A", wav_a, 0);
    chk("R4 B stays set", wav_b, 1);
  endtask

  task automatic t_pwm_duty(input int top, input int ca, input int cb,
                            input int ea, input int eb, input string tag);
    int ha, hb;
    do_reset();
    top_val = 16'(top); cmp_a = 16'(ca); cmp_b = 16'(cb);
    wgm_hi = 2'b01;
    wr_ctl(8'b10_11_0011);
    cnt_en = 1'b1;
    count_high(2 * (top + 1), ha, hb);
    count_high(top + 1, ha, hb);
    chk({tag, " A action 10 duty"}, ha, ea);
    chk({tag, " B action 11 duty"}, hb, eb);
  endtask

  task automatic t_hold();
    logic sa, sb;
    int ha, hb;
    cnt_en = 1'b0;
    @(negedge clk);
    sa = wav_a; sb = wav_b;
    count_high(20, ha, hb);
    chk("R12 A held", ha, sa ? 20 : 0);
    chk("R12 B held", hb, sb ? 20 : 0);
  endtask

  task automatic t_pwm_toggle();
    int ta, tb;
    do_reset();
    top_val = 16'd5; cmp_a = 16'd2; cmp_b = 16'd2;
    wgm_hi = 2'b11;
    wr_ctl(8'b01_01_0011);
    cnt_en = 1'b1;
    count_tgl(12, ta, tb);
    chk("R8 A toggles with mode bit 3", ta, 2);
    chk("R8 B never toggles", tb, 0);
    chk("R9 ovr_b with action 01", ovr_b, 1);
    wgm_hi = 2'b01;
    count_tgl(12, ta, tb);
    chk("R8 A still without mode bit 3", ta, 0);
  endtask

  task automatic t_buffer();
    int hi, ha, hb;
    logic prev;
    do_reset();
    top_val = 16'd9; cmp_a = 16'd7;
    wgm_hi = 2'b01;
    wr_ctl(8'b10_00_0011);
    cnt_en = 1'b1;
    repeat (25) @(negedge clk);
    prev = wav_a;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if (!prev && wav_a) break;
      prev = wav_a;
    end
    hi = wav_a ? 1 : 0;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      if (wav_a) hi++;
      if (i == 2) cmp_a = 16'd3;
    end
    chk("R11 old compare in current period", hi, 8);
    count_high(10, ha, hb);
    chk("R11 new compare after wrap", ha, 4);
  endtask

  task automatic t_dir();
    do_reset();
    wr_ctl(8'b01_00_0000);
    dir_b = 1'b1;
    @(negedge clk);
    chk("R9 oe_a needs dir", oe_a, 0);
    chk("R9 oe_b needs action", oe_b, 0);
    dir_a = 1'b1;
    @(negedge clk);
    chk("R9 oe_a enabled", oe_a, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset_ctl();
    t_toggle();
    t_set_clr();
    t_pwm_duty(9, 4, 3, 5, 6, "R5 R6 pattern1");
    t_hold();
    t_pwm_duty(15, 0, 14, 1, 1, "R5 R6 pattern2");
    t_pwm_duty(7, 7, 7, 8, 0, "R7 compare equals TOP");
    t_pwm_toggle();
    t_buffer();
    t_dir();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule